// File: doc/BRIEF.md
# Serial Segment-Display Command Front End

This block sits between a slow four-wire serial host link and the display memory of a 32-column, 4-row segment display. The host drives a shift clock, a data line, a command/data select line and an active-low select. The block samples these wires with its own system clock and gathers them into bytes. Each byte is then either decoded as a command or treated as display data.

Commands can load the display address, write one 4-bit column value, and change the display mode. Data bytes fill two adjacent columns at once. A single column address is kept for all writes. It moves forward by itself after every write and wraps from the last column back to column 0. The block has no memory of its own. It sends each column write out as a strobe with an address and a nibble, one nibble per strobe. In that nibble, bit k drives common row k. The mode outputs tell the display driver whether the display is blank, shows every segment, or shows the memory contents. An active-low clear pin sets the mode to blank and the address to 0.

Top module: `lcd_serial_front`

## Requirements
- R1: A bit on `ser_data` is shifted in on each rising edge of `ser_clk` while `ser_cs_n` is low, most significant bit first. Clock edges while `ser_cs_n` is high have no effect.
- R2: `ser_cmd` is taken at the eighth rising clock edge of a byte. High means the byte is a command. Low means the byte is display data.
- R3: Command `000aaaaa` loads the column address with `aaaaa`. It makes no write.
- R4: Command `001xxxxx` sets the lit-everything mode (`disp_on`=1, `force_all`=1) and makes no write.
- R5: Command `010xxxxx` blanks the display (`disp_on`=0, `force_all`=0) and makes no write.
- R6: Command `011xxxxx` sets normal display from memory (`disp_on`=1, `force_all`=0).
- R7: Command `100xdddd` makes exactly one write of `dddd` at the current address and then advances the address by 1. Nibble bit k is common row k.
- R8: A data byte makes exactly two writes on consecutive system clocks. The high nibble goes to the current address and the low nibble to the next address. The net advance is 2.
- R9: The column address that follows 31 is 0, for both write types.
- R10: Command `110xxxxx`, or a low level on `clear_n`, blanks the display and sets the address to 0.
- R11: If `ser_cs_n` rises before the eighth clock, the partial byte is dropped, and the next byte is framed from its first bit.
- R12: Command codes `101xxxxx` and `111xxxxx` change neither the mode nor the address and make no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clear_n | input | 1 | Active-low display clear pin, asynchronous to clk |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_cmd | input | 1 | Command (1) or data (0) select |
| ser_cs_n | input | 1 | Active-low select |
| wr_en | output | 1 | One-cycle column write strobe |
| wr_addr | output | 5 | Column address of the write |
| wr_nib | output | 4 | Column nibble, bit k = common row k |
| disp_on | output | 1 | Display is driven (not blank) |
| force_all | output | 1 | Every segment is lit regardless of memory |

## Verification
Most faults in the address counter are not visible when they happen. They show up only at the next write strobe, which lands in the wrong column. The bench therefore writes a shadow image of the memory from the strobes and checks where every write lands, from every start address, for both step sizes, including the wrap. A bit counter left out of step by an aborted byte shows up on the very next byte. That byte would be decoded as a different command, or as no command at all. Faults in the mode state show on the two flag outputs a few system clocks after the byte's eighth edge.

// File: rtl/lcd_if_pkg.sv
package lcd_if_pkg;
    typedef enum logic [1:0] {
        MODE_BLANK = 2'd0,
        MODE_ALL   = 2'd1,
        MODE_RAM   = 2'd2
    } disp_mode_e;

    localparam logic [2:0] OP_ADDR = 3'b000;
    localparam logic [2:0] OP_ALL  = 3'b001;
    localparam logic [2:0] OP_OFF  = 3'b010;
    localparam logic [2:0] OP_RUN  = 3'b011;
    localparam logic [2:0] OP_NIB  = 3'b100;
    localparam logic [2:0] OP_RST  = 3'b110;
endpackage

// File: rtl/lcd_in_sync.sv
module lcd_in_sync #(
    parameter int          W       = 5,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            sy_q <= sy_d;
        end
    end

    assign dout = sy_q.s2;
endmodule

// File: rtl/lcd_byte_rx.sv
module lcd_byte_rx #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            sdat,
    input  logic            scmd,
    input  logic            cs_n,
    output logic            byte_vld,
    output logic [BITS-1:0] byte_out,
    output logic            byte_is_cmd
);
    localparam int CW = $clog2(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    typedef struct packed {
        logic            sclk_prev;
        logic [BITS-1:0] sh;
        logic [CW-1:0]   cnt;
        logic            vld;
        logic [BITS-1:0] byte_v;
        logic            is_cmd;
    } rx_t;

    rx_t rx_d, rx_q;
    logic sclk_rise;
    logic [BITS-1:0] sh_next;

    assign sclk_rise = sclk && !rx_q.sclk_prev;
    assign sh_next   = {rx_q.sh[BITS-2:0], sdat};

    always_comb begin
        rx_d           = rx_q;
        rx_d.sclk_prev = sclk;
        rx_d.vld       = 1'b0;
        if (cs_n) begin
            rx_d.cnt = '0;
        end else if (sclk_rise) begin
            rx_d.sh = sh_next;
            if (rx_q.cnt == LAST) begin
                rx_d.vld    = 1'b1;
                rx_d.byte_v = sh_next;
                rx_d.is_cmd = scmd;
                rx_d.cnt    = '0;
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_vld    = rx_q.vld;
    assign byte_out    = rx_q.byte_v;
    assign byte_is_cmd = rx_q.is_cmd;

    assert_abort_clears_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (rx_q.cnt == '0))
        else $error("bit count not cleared while deselected");

    assert_no_byte_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !byte_vld)
        else $error("byte completed while deselected");
endmodule

// File: rtl/lcd_cmd_core.sv
module lcd_cmd_core
    import lcd_if_pkg::*;
#(
    parameter int COLS = 32,
    parameter int ROWS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_n,
    input  logic                     byte_vld,
    input  logic [7:0]               byte_in,
    input  logic                     is_cmd,
    output logic                     wr_en,
    output logic [$clog2(COLS)-1:0]  wr_addr,
    output logic [ROWS-1:0]          wr_nib,
    output logic                     disp_on,
    output logic                     force_all
);
    localparam int AW = $clog2(COLS);
    localparam logic [AW-1:0] LAST_COL = AW'(COLS - 1);

    typedef struct packed {
        disp_mode_e      mode;
        logic [AW-1:0]   addr;
        logic            pend;
        logic [ROWS-1:0] pend_nib;
        logic            wr_en;
        logic [AW-1:0]   wr_addr;
        logic [ROWS-1:0] wr_nib;
    } core_t;

    core_t st_d, st_q;

    function automatic logic [AW-1:0] col_next(input logic [AW-1:0] a);
        return (a == LAST_COL) ? '0 : a + 1'b1;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (st_q.pend) begin
            st_d.wr_en   = 1'b1;
            st_d.wr_addr = st_q.addr;
            st_d.wr_nib  = st_q.pend_nib;
            st_d.addr    = col_next(st_q.addr);
            st_d.pend    = 1'b0;
        end else if (byte_vld) begin
            if (!is_cmd) begin
                st_d.wr_en    = 1'b1;
                st_d.wr_addr  = st_q.addr;
                st_d.wr_nib   = byte_in[7:4];
                st_d.pend_nib = byte_in[3:0];
                st_d.pend     = 1'b1;
                st_d.addr     = col_next(st_q.addr);
            end else begin
                case (byte_in[7:5])
                    OP_ADDR: st_d.addr = AW'(byte_in[4:0]);
                    OP_ALL:  st_d.mode = MODE_ALL;
                    OP_OFF:  st_d.mode = MODE_BLANK;
                    OP_RUN:  st_d.mode = MODE_RAM;
                    OP_NIB: begin
                        st_d.wr_en   = 1'b1;
                        st_d.wr_addr = st_q.addr;
                        st_d.wr_nib  = byte_in[3:0];
                        st_d.addr    = col_next(st_q.addr);
                    end
                    OP_RST: begin
                        st_d.mode = MODE_BLANK;
                        st_d.addr = '0;
                    end
                    default: ;
                endcase
            end
        end
        if (!clr_n) begin
            st_d.mode  = MODE_BLANK;
            st_d.addr  = '0;
            st_d.pend  = 1'b0;
            st_d.wr_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_BLANK, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en     = st_q.wr_en;
    assign wr_addr   = st_q.wr_addr;
    assign wr_nib    = st_q.wr_nib;
    assign disp_on   = (st_q.mode != MODE_BLANK);
    assign force_all = (st_q.mode == MODE_ALL);

    assert_data_pair_step_R8: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (byte_vld && !is_cmd && !st_q.pend) |=> wr_en ##1 (wr_en && wr_addr == col_next($past(wr_addr))))
        else $error("data byte did not write two adjacent columns");

    assert_wrap_to_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == LAST_COL && $past(clr_n)) |-> (st_q.addr == '0))
        else $error("address did not wrap after last column");

    assert_clear_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (!disp_on && st_q.addr == '0 && !wr_en))
        else $error("clear pin did not blank and zero the address");

    assert_all_on_implies_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        force_all |-> disp_on)
        else $error("lit-everything mode with display blank");

    assert_mode_cmd_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && is_cmd && byte_in[7:5] != OP_NIB && !st_q.pend) |=> !wr_en)
        else $error("non-write command produced a write");
endmodule

// File: rtl/lcd_serial_front.sv
module lcd_serial_front #(
    parameter int COLS = 32,
    parameter int ROWS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_n,
    input  logic                    ser_clk,
    input  logic                    ser_data,
    input  logic                    ser_cmd,
    input  logic                    ser_cs_n,
    output logic                    wr_en,
    output logic [$clog2(COLS)-1:0] wr_addr,
    output logic [ROWS-1:0]         wr_nib,
    output logic                    disp_on,
    output logic                    force_all
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0] raw_in, syn_out;
    logic       byte_vld, byte_is_cmd;
    logic [7:0] byte_val;

    assign raw_in = {clear_n, ser_cs_n, ser_cmd, ser_data, ser_clk};

    lcd_in_sync #(.W(NSYNC), .RST_VAL(5'b11000)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (syn_out)
    );

    lcd_byte_rx #(.BITS(8)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (syn_out[0]),
        .sdat       (syn_out[1]),
        .scmd       (syn_out[2]),
        .cs_n       (syn_out[3]),
        .byte_vld   (byte_vld),
        .byte_out   (byte_val),
        .byte_is_cmd(byte_is_cmd)
    );

    lcd_cmd_core #(.COLS(COLS), .ROWS(ROWS)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (syn_out[4]),
        .byte_vld (byte_vld),
        .byte_in  (byte_val),
        .is_cmd   (byte_is_cmd),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_nib   (wr_nib),
        .disp_on  (disp_on),
        .force_all(force_all)
    );
endmodule

// File: tb/lcd_serial_front_bench.sv
module lcd_serial_front_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_n = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_cmd = 1'b0, ser_cs_n = 1'b1;
    logic wr_en, disp_on, force_all;
    logic [4:0] wr_addr;
    logic [3:0] wr_nib;

    int checks = 0, fails = 0, wcount = 0;
    logic [3:0] shadow [32];
    int last_addr = -1, prev_addr = -1;
    logic [3:0] last_nib = '0, prev_nib = '0;

    always #10 clk = ~clk;

    lcd_serial_front u_lcd_serial_front (
        .clk(clk), .rst_n(rst_n), .clear_n(clear_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_cmd(ser_cmd), .ser_cs_n(ser_cs_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_nib(wr_nib),
        .disp_on(disp_on), .force_all(force_all)
    );

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            shadow[wr_addr] = wr_nib;
            prev_addr = last_addr;
            prev_nib  = last_nib;
            last_addr = int'(wr_addr);
            last_nib  = wr_nib;
            wcount++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic cmd, input logic [7:0] b, input int nbits);
        ser_cs_n = 1'b0;
        cyc(4);
        for (int i = 0; i < nbits; i++) begin
            ser_data = b[7-i];
            ser_cmd  = cmd;
            cyc(4);
            ser_clk = 1'b1;
            cyc(4);
            ser_clk = 1'b0;
        end
        cyc(4);
        ser_cs_n = 1'b1;
        cyc(12);
    endtask

    task automatic cmd(input logic [7:0] b);
        xfer(1'b1, b, 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int w0;
        logic [3:0] v;
        logic [7:0] b;
        cyc(5);
        rst_n = 1'b1;
        cyc(5);
        // reset state
        chk(!disp_on && !force_all, "R5 reset blank", {disp_on, force_all}, 0);
        chk(wcount == 0, "R5 reset no writes", wcount, 0);

        // mode commands
        cmd(8'h7F);
        chk(disp_on && !force_all, "R6 normal mode", {disp_on, force_all}, 2);
        w0 = wcount;
        cmd(8'h3A);
        chk(disp_on && force_all, "R4 all-on mode", {disp_on, force_all}, 3);
        chk(wcount == w0, "R4 no write", wcount, w0);
        cmd(8'h55);
        chk(!disp_on && !force_all, "R5 blank mode", {disp_on, force_all}, 0);
        chk(wcount == w0, "R5 no write", wcount, w0);

        // rewrite sweep: every start address, R3 R7 R9
        for (int a = 0; a < 32; a++) begin
            v = 4'((a * 7 + 3) & 15);
            cmd(8'(a));
            w0 = wcount;
            cmd({4'b1001, v});
            chk(wcount == w0 + 1, "R7 single strobe", wcount - w0, 1);
            chk(last_addr == a && last_nib == v, "R3 R7 write at loaded address",
                last_addr * 16 + int'(last_nib), a * 16 + int'(v));
            cmd({4'b1000, ~v});
            chk(last_addr == (a + 1) % 32 && last_nib == ~v, "R7 R9 advance by one",
                last_addr, (a + 1) % 32);
        end

        // data byte sweep: R8 R9 R2
        for (int a = 0; a < 32; a++) begin
            b = 8'((a * 37 + 11) & 255);
            cmd(8'(a));
            w0 = wcount;
            xfer(1'b0, b, 8);
            chk(wcount == w0 + 2, "R8 two strobes", wcount - w0, 2);
            chk(prev_addr == a && prev_nib == b[7:4], "R8 high nibble first",
                prev_addr * 16 + int'(prev_nib), a * 16 + int'(b[7:4]));
            chk(last_addr == (a + 1) % 32 && last_nib == b[3:0], "R8 R9 low nibble next",
                last_addr * 16 + int'(last_nib), ((a + 1) % 32) * 16 + int'(b[3:0]));
            cmd(8'h85);
            chk(last_addr == (a + 2) % 32, "R8 R9 net advance two", last_addr, (a + 2) % 32);
        end

        // R2: same byte as command vs data
        cmd(8'h0C);
        w0 = wcount;
        xfer(1'b1, 8'h1F, 8);
        chk(wcount == w0, "R2 command byte not data", wcount, w0);
        cmd(8'h86);
        chk(last_addr == 31 && last_nib == 4'h6, "R2 R3 address from command", last_addr, 31);

        // R11 abort partial byte
        cmd(8'h04);
        w0 = wcount;
        xfer(1'b1, 8'hFF, 5);
        cmd(8'h8A);
        chk(wcount == w0 + 1 && last_addr == 4 && last_nib == 4'hA, "R11 partial byte dropped",
            last_addr * 16 + int'(last_nib), 4 * 16 + 10);

        // R1 clocks ignored while deselected
        cmd(8'h09);
        w0 = wcount;
        ser_data = 1'b1;
        ser_cmd  = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cyc(4); ser_clk = 1'b1; cyc(4); ser_clk = 1'b0;
        end
        cyc(12);
        cmd(8'h83);
        chk(wcount == w0 + 1 && last_addr == 9 && last_nib == 4'h3, "R1 deselected clocks ignored",
            last_addr * 16 + int'(last_nib), 9 * 16 + 3);

        // R10 reset command
        cmd(8'h60);
        cmd(8'h11);
        cmd(8'hC7);
        chk(!disp_on && !force_all, "R10 command blanks", {disp_on, force_all}, 0);
        cmd(8'h8E);
        chk(last_addr == 0 && last_nib == 4'hE, "R10 command zeroes address", last_addr, 0);

        // R10 clear pin
        cmd(8'h20);
        cmd(8'h0D);
        clear_n = 1'b0;
        cyc(10);
        clear_n = 1'b1;
        cyc(6);
        chk(!disp_on && !force_all, "R10 pin blanks", {disp_on, force_all}, 0);
        cmd(8'h82);
        chk(last_addr == 0 && last_nib == 4'h2, "R10 pin zeroes address", last_addr, 0);

        // R12 unused codes
        cmd(8'h60);
        cmd(8'h06);
        w0 = wcount;
        cmd(8'hE5);
        cmd(8'hA3);
        chk(disp_on && !force_all, "R12 mode unchanged", {disp_on, force_all}, 2);
        chk(wcount == w0, "R12 no write", wcount, w0);
        cmd(8'h87);
        chk(last_addr == 6 && last_nib == 4'h7, "R12 address unchanged", last_addr, 6);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule